// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is one bank of sixteen general-purpose pins sitting behind a 16-bit register port. Software sets, per pin, whether the pin drives (direction), what it drives (the bank's output register or an external function signal chosen by the alternate-select register), and how it raises an interrupt. Every pin is brought through a synchronizer, and the synchronized level can be read back at any time, whether the pin is an input or an output.

Each pin picks its own trigger: edge or level, plus a polarity for each kind. Detected events latch into an interrupt status register. Status latching ignores the mask, so masking a pin only gates whether its latched bit reaches the single bank interrupt line. Software clears status by writing to the status register: every bit written as 0 is cleared. A detection in the same cycle as a clear wins, so no event is lost.

The register port is a plain control interface: a write takes effect on the clock edge where `reg_wr` is high, reads are combinational from `reg_addr`, and there is no back-pressure. Pin and interrupt signals are plain levels.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset the direction, output, alternate-select, trigger-kind, edge-polarity, level-polarity and status registers read 0, the mask reads 16'hFFFF, and `irq` is 0.
- R2: Register address 0 is direction. A 1 bit makes the pin an output, and `pin_oe` equals the direction register.
- R3: Address 1 is the output register and address 2 is alternate-select. Each bit of `pin_out` is `alt_in` when its select bit is 1, and the output register bit when it is 0.
- R4: Address 7 returns the pin levels, delayed through two flops: a value present on `pin_in` before edge k reads back after edge k+1. Writes to address 7 have no effect.
- R5: Address 4 holds the trigger kind (0 = edge, 1 = level) and address 5 holds the edge polarity (0 = rising, 1 = falling). An edge pin sets its status bit when the synchronized level changes in the selected direction, whether it is masked or not.
- R6: Address 6 holds the level polarity (0 = high active, 1 = low active). A level pin sets its status bit on every cycle that its synchronized level is active.
- R7: Address 8 is the interrupt status. A write replaces it with `status & wdata`, so writing 0 clears every bit.
- R8: A detection in the same cycle as a status write still leaves its bit set after that write.
- R9: `irq` is 1 exactly one cycle after a cycle in which some status bit is set with its mask bit clear.
- R10: Address 3 is the mask. A set bit blocks that pin from `irq`, and a mask of all ones keeps `irq` at 0.
- R11: Addresses 9 to 15 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| pin_in | input | 16 | Level seen on each pin |
| alt_in | input | 16 | Per-pin alternate function output value |
| pin_out | output | 16 | Value driven on each pin |
| pin_oe | output | 16 | Output enable per pin |
| irq | output | 1 | Registered bank interrupt |

## Verification
The hardest case to reach is a status clear that lands on the exact clock edge where a new detection is latched. The synchronizer puts that edge two cycles after the pin changes. The bench has one directed sequence that places the clearing write on that edge, and a long random phase that mixes pin toggles with random writes, including status writes, so the collision occurs many times. A behavioural model with its own synchronizer and trigger logic predicts `irq`, the pin outputs and the read data for every cycle, including the cycles where the clear and the detection coincide.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    RA_DIR  = 4'd0,
    RA_OUT  = 4'd1,
    RA_ALT  = 4'd2,
    RA_MASK = 4'd3,
    RA_KIND = 4'd4,
    RA_EPOL = 4'd5,
    RA_LPOL = 4'd6,
    RA_PINS = 4'd7,
    RA_STAT = 4'd8
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] stg;
  logic                         seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg  <= '0;
      seen <= 1'b0;
    end else begin
      seen <= 1'b1;
      for (int k = 0; k < STAGES; k++) begin
        if (k == 0) stg[k] <= din;
        else        stg[k] <= stg[k-1];
      end
    end
  end

  assign dout = stg[LAST];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_chk
      if (g == 0) begin : g_head
        // R4: first stage captures the pin
        a_r4_sync_head: assert property (@(posedge clk) disable iff (!rst_n)
          seen |-> (stg[0] == $past(din)));
      end else begin : g_tail
        // R4: each later stage shifts the previous one
        a_r4_sync_shift: assert property (@(posedge clk) disable iff (!rst_n)
          seen |-> (stg[g] == $past(stg[g-1])));
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] smp,
  input  logic [WIDTH-1:0] kind,
  input  logic [WIDTH-1:0] epol,
  input  logic [WIDTH-1:0] lpol,
  output logic [WIDTH-1:0] hit
);
  logic [WIDTH-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= smp;
  end

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_pin
      logic rise, fall, edge_hit, lvl_hit;
      assign rise     = smp[i] & ~prev[i];
      assign fall     = ~smp[i] & prev[i];
      assign edge_hit = epol[i] ? fall : rise;
      assign lvl_hit  = lpol[i] ? ~smp[i] : smp[i];
      assign hit[i]   = kind[i] ? lvl_hit : edge_hit;
    end
  endgenerate
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_bank_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [WIDTH-1:0]  hit,
  input  logic [WIDTH-1:0]  pins,
  output logic [WIDTH-1:0]  dir,
  output logic [WIDTH-1:0]  outv,
  output logic [WIDTH-1:0]  alt,
  output logic [WIDTH-1:0]  mask,
  output logic [WIDTH-1:0]  kind,
  output logic [WIDTH-1:0]  epol,
  output logic [WIDTH-1:0]  lpol,
  output logic [WIDTH-1:0]  status,
  output logic [WIDTH-1:0]  rdata
);
  localparam logic [WIDTH-1:0] MASK_RST = '1;

  logic stat_wr;
  assign stat_wr = wr && (addr == RA_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir  <= '0;
      outv <= '0;
      alt  <= '0;
      mask <= MASK_RST;
      kind <= '0;
      epol <= '0;
      lpol <= '0;
    end else if (wr) begin
      case (addr)
        RA_DIR:  dir  <= wdata;
        RA_OUT:  outv <= wdata;
        RA_ALT:  alt  <= wdata;
        RA_MASK: mask <= wdata;
        RA_KIND: kind <= wdata;
        RA_EPOL: epol <= wdata;
        RA_LPOL: lpol <= wdata;
        default: ;
      endcase
    end
  end

  // new detections are ORed after the clear so they survive it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       status <= '0;
    else if (stat_wr) status <= (status & wdata) | hit;
    else              status <= status | hit;
  end

  always_comb begin
    case (addr)
      RA_DIR:  rdata = dir;
      RA_OUT:  rdata = outv;
      RA_ALT:  rdata = alt;
      RA_MASK: rdata = mask;
      RA_KIND: rdata = kind;
      RA_EPOL: rdata = epol;
      RA_LPOL: rdata = lpol;
      RA_PINS: rdata = pins;
      RA_STAT: rdata = status;
      default: rdata = '0;
    endcase
  end

  // R7: a zero write with nothing detected empties the status
  a_r7_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && (wdata == '0) && (hit == '0)) |=> (status == '0));

  // R8: every detected pin is set on the next cycle, clear or not
  a_r8_detect_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((status & $past(hit)) == $past(hit)));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int PINS        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [PINS-1:0]   reg_wdata,
  output logic [PINS-1:0]   reg_rdata,
  input  logic [PINS-1:0]   pin_in,
  input  logic [PINS-1:0]   alt_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic              irq
);
  localparam logic [PINS-1:0] ALL_MASKED = '1;

  logic [PINS-1:0] smp, hit;
  logic [PINS-1:0] dir, outv, alt, mask, kind, epol, lpol, status;
  logic            seen;

  gpio_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(smp)
  );

  gpio_detect #(.WIDTH(PINS)) u_det (
    .clk(clk), .rst_n(rst_n), .smp(smp),
    .kind(kind), .epol(epol), .lpol(lpol), .hit(hit)
  );

  gpio_regs #(.WIDTH(PINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .hit(hit), .pins(smp),
    .dir(dir), .outv(outv), .alt(alt), .mask(mask), .kind(kind),
    .epol(epol), .lpol(lpol), .status(status), .rdata(reg_rdata)
  );

  genvar i;
  generate
    for (i = 0; i < PINS; i++) begin : g_out
      assign pin_out[i] = alt[i] ? alt_in[i] : outv[i];
    end
  endgenerate

  assign pin_oe = dir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq  <= 1'b0;
      seen <= 1'b0;
    end else begin
      irq  <= |(status & ~mask);
      seen <= 1'b1;
    end
  end

  // R9: line reflects unmasked status one cycle later
  a_r9_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (irq == $past(|(status & ~mask))));

  // R10: fully masked bank never raises the line
  a_r10_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == ALL_MASKED) |=> !irq);
endmodule

// File: tb/sim_gpio_irq_bank.sv
module sim_gpio_irq_bank;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 100000;

  logic        clk   = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr    = 1'b0;
  logic [3:0]  addr  = 4'd0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] pin_in = 16'h0;
  logic [15:0] alt_in = 16'h0;
  logic [15:0] rdata, pin_out, pin_oe;
  logic        irq;

  gpio_irq_bank u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .pin_in(pin_in),
    .alt_in(alt_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference state
  logic [15:0] m_dir = 0, m_out = 0, m_alt = 0, m_mask = 16'hFFFF;
  logic [15:0] m_kind = 0, m_epol = 0, m_lpol = 0, m_st = 0;
  logic [15:0] m_s1 = 0, m_s2 = 0, m_prev = 0, m_d;
  logic        m_irq = 0;

  int    vectors = 0;
  int    errs    = 0;
  bit    done    = 0;
  string phase   = "reset";

  function automatic logic [15:0] m_detect();
    logic [15:0] d;
    for (int b = 0; b < 16; b++) begin
      if (m_kind[b]) d[b] = m_lpol[b] ? !m_s2[b] : m_s2[b];
      else if (m_epol[b]) d[b] = !m_s2[b] && m_prev[b];
      else d[b] = m_s2[b] && !m_prev[b];
    end
    return d;
  endfunction

  function automatic logic [15:0] m_read(input logic [3:0] a);
    case (a)
      4'd0: return m_dir;
      4'd1: return m_out;
      4'd2: return m_alt;
      4'd3: return m_mask;
      4'd4: return m_kind;
      4'd5: return m_epol;
      4'd6: return m_lpol;
      4'd7: return m_s2;
      4'd8: return m_st;
      default: return 16'h0;
    endcase
  endfunction

  function automatic string rtag(input logic [3:0] a);
    case (a)
      4'd0: return "R2 direction readback";
      4'd1, 4'd2: return "R3 output/alt readback";
      4'd3: return "R10 mask readback";
      4'd4, 4'd5: return "R5 edge config readback";
      4'd6: return "R6 level config readback";
      4'd7: return "R4 pin level";
      4'd8: return "R7 status";
      default: return "R11 unmapped read";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = 0; m_out = 0; m_alt = 0; m_mask = 16'hFFFF;
      m_kind = 0; m_epol = 0; m_lpol = 0; m_st = 0;
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_irq = 0;
    end else begin
      m_d   = m_detect();
      m_irq = |(m_st & ~m_mask);
      if (wr && addr == 4'd8) m_st = (m_st & wdata) | m_d;
      else                    m_st = m_st | m_d;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
      if (wr) begin
        case (addr)
          4'd0: m_dir  = wdata;
          4'd1: m_out  = wdata;
          4'd2: m_alt  = wdata;
          4'd3: m_mask = wdata;
          4'd4: m_kind = wdata;
          4'd5: m_epol = wdata;
          4'd6: m_lpol = wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string tag);
    vectors++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s [%s] got %h expected %h", tag, phase, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk({15'h0, irq}, {15'h0, m_irq}, "R9 irq line");
      chk(pin_oe, m_dir, "R2 pin_oe");
      chk(pin_out, (m_alt & alt_in) | (~m_alt & m_out), "R3 pin_out");
      chk(rdata, m_read(addr), rtag(addr));
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      step();
      wr   = 1'b0;
      addr = (addr >= 4'd9) ? 4'd0 : addr + 4'd1;
    end
  endtask

  task automatic wreg(input logic [3:0] a, input logic [15:0] d);
    step();
    wr = 1'b1; addr = a; wdata = d;
    step();
    wr = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired in phase [%s]", phase);
      finish_run();
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    phase = "R1 reset values";
    idle(12);

    phase = "R2 R3 direction and alternate select";
    wreg(4'd0, 16'hF0F0);
    wreg(4'd1, 16'hAAAA);
    wreg(4'd2, 16'h00FF);
    alt_in = 16'h1234; idle(4);
    alt_in = 16'hEDCB; idle(4);

    phase = "R4 pin levels";
    for (int n = 0; n < 20; n++) begin
      pin_in = 16'($urandom());
      idle(3);
    end
    wreg(4'd7, 16'h5A5A);
    idle(4);

    phase = "R5 R10 edges while masked";
    wreg(4'd8, 16'h0000);
    wreg(4'd4, 16'h0000);
    wreg(4'd5, 16'h00F0);
    pin_in = 16'h0000; idle(5);
    wreg(4'd8, 16'h0000);
    pin_in = 16'hFFFF; idle(5);
    pin_in = 16'h0000; idle(5);

    phase = "R9 unmask one pin";
    wreg(4'd3, 16'hFFFE); idle(4);
    wreg(4'd3, 16'hFFFF); idle(4);

    phase = "R7 partial and full clear";
    wreg(4'd3, 16'h0000);
    wreg(4'd8, 16'hFF00); idle(3);
    wreg(4'd8, 16'h0000); idle(5);

    phase = "R6 level triggers";
    wreg(4'd4, 16'hFFFF);
    wreg(4'd6, 16'h0F0F);
    pin_in = 16'h00FF; idle(5);
    wreg(4'd8, 16'h0000); idle(3);
    pin_in = 16'hFF00; idle(5);

    phase = "R8 clear on the detection edge";
    wreg(4'd4, 16'h0000);
    wreg(4'd5, 16'h0000);
    pin_in = 16'h0000; idle(5);
    wreg(4'd8, 16'h0000); idle(2);
    step(); pin_in = 16'h0180;
    step();
    step(); wr = 1'b1; addr = 4'd8; wdata = 16'h0000;
    step(); wr = 1'b0;
    idle(10);

    phase = "R11 unmapped addresses";
    wreg(4'd9,  16'hFFFF);
    wreg(4'd15, 16'h1234);
    step(); addr = 4'd15;
    step(); addr = 4'd12;
    idle(12);

    phase = "random mix";
    for (int n = 0; n < 4000; n++) begin
      step();
      pin_in = ($urandom_range(0, 3) == 0) ? 16'($urandom()) : pin_in;
      alt_in = 16'($urandom());
      wr     = ($urandom_range(0, 2) == 0);
      addr   = 4'($urandom_range(0, 11));
      wdata  = ($urandom_range(0, 3) == 0) ? 16'h0000 : 16'($urandom());
    end
    idle(5);
    finish_run();
  end
endmodule